// File: doc/BRIEF.md
# Overload Retry Duty-Cycle Controller

This block gates the enable of one switching output channel once an overload (short-circuit) flag is seen. While the flag keeps coming back, the channel is not held off for good. It is driven in a repeating pattern instead: a cool-down window with the output disabled, then a drive window of fixed length with the output enabled. At the end of each drive window the overload flag is sampled. If it is still set, another cool-down starts. If it is clear, the channel returns to continuous enable.

The drive window always lasts `ON_TICKS` ticks, and a slow timebase tick (on the order of microseconds) paces both windows. The cool-down length is the only thing the configuration changes. A 2-bit code picks one of four on:off ratios, and the cool-down lasts `ON_TICKS × (ratio − 1)` ticks, so one full period is `ratio × ON_TICKS`. The code is captured when a cool-down window starts, so a window that is already running is never shortened or lengthened.

Top module: `ovl_retry_ctrl`

## Requirements
- R1: While synchronous reset is high, and on the cycle after it, `out_en_o` is 1 and `pulse_act_o` is 0.
- R2: In the idle state, a high `ovl_i` at a clock edge makes `out_en_o` 0 and `pulse_act_o` 1 from that edge on, whether or not `tick_i` is high.
- R3: A cool-down window keeps `out_en_o` at 0 for exactly `ON_TICKS × (ratio − 1)` ticks, counting the starting edge as the first. The ratio code maps as follows: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 10 and 2'b11 gives 15.
- R4: After a cool-down window, `out_en_o` is 1 for exactly `ON_TICKS` ticks, whatever the ratio code, while `pulse_act_o` stays 1.
- R5: The ratio code is sampled only at the edge that starts a cool-down window. A change during a cool-down or drive window does not alter that window, and it applies from the next cool-down window.
- R6: If `ovl_i` is high at the tick that ends a drive window, a new cool-down window starts at that edge and `pulse_act_o` stays 1.
- R7: If `ovl_i` is low at the tick that ends a drive window, `out_en_o` stays 1 and `pulse_act_o` returns to 0 at that edge.
- R8: Clock edges without `tick_i` do not advance either window. The outputs hold their values.
- R9: In pulsed mode, `ovl_i` is ignored at every edge except the one that ends a drive window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ovl_i | input | 1 | Overload detected on the channel |
| tick_i | input | 1 | Single-cycle timebase tick that paces both windows |
| ratio_sel_i | input | 2 | On:off ratio code (00=1:4, 01=1:8, 10=1:10, 11=1:15) |
| out_en_o | output | 1 | Gated enable for the output switch |
| pulse_act_o | output | 1 | High while pulsed retry mode is active |

## Verification
Each of the four ratio codes is run through a full cool-down and drive cycle with a tick on every clock. Getting all four window lengths right rules out a wrong entry in the ratio map and an off-by-one in either window. Separate sequences cover the following:
- Repeated overload at the end of a drive window, which separates retry from exit.
- A ratio change inside both kinds of window, which shows when the code is latched.
- Clock edges without ticks inside both windows, which shows that only ticks advance the timer.
- Overload toggling inside the windows, which must have no effect.
- A reset in the middle of a window.

// File: rtl/ovl_retry_pkg.sv
package ovl_retry_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_OFF  = 2'd1,
      ST_ON   = 2'd2
   } ovl_state_e;

   // Period ratio selected by the 2-bit code
   function automatic logic [3:0] ratio_of(input logic [1:0] code);
      case (code)
         2'b00:   ratio_of = 4'd4;
         2'b01:   ratio_of = 4'd8;
         2'b10:   ratio_of = 4'd10;
         default: ratio_of = 4'd15;
      endcase
   endfunction

endpackage

// File: rtl/ovl_off_len.sv
module ovl_off_len #(
   parameter int unsigned ON_TICKS = 100,
   parameter int unsigned CNT_W    = 11
) (
   input  logic [1:0]       ratio_sel_i,
   output logic [CNT_W-1:0] off_len_o
);
   import ovl_retry_pkg::*;

   localparam bit          IS_POW2 = ((ON_TICKS & (ON_TICKS - 1)) == 0);
   localparam int unsigned SHIFT   = (ON_TICKS > 1) ? $clog2(ON_TICKS) : 0;

   logic [3:0]       ratio_m1;
   logic [CNT_W-1:0] ratio_m1_w;

   always_comb begin
      ratio_m1   = ratio_of(ratio_sel_i) - 4'd1;
      ratio_m1_w = CNT_W'(ratio_m1);
   end

   generate
      if (IS_POW2) begin : g_shift
         assign off_len_o = ratio_m1_w << SHIFT;
      end else begin : g_mult
         assign off_len_o = ratio_m1_w * CNT_W'(ON_TICKS);
      end
   endgenerate

endmodule

// File: rtl/ovl_tick_timer.sv
module ovl_tick_timer #(
   parameter int unsigned CNT_W = 11
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         cnt_o <= '0;
      end else if (load_i) begin
         cnt_o <= load_val_i;
      end else if (tick_i && (cnt_o != '0)) begin
         cnt_o <= cnt_o - 1'b1;
      end
   end

   assign zero_o = (cnt_o == '0);

   // R8
   tick_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!load_i && !tick_i) |=> $stable(cnt_o))
      else $error("timer moved without a tick");

endmodule

// File: rtl/ovl_retry_fsm.sv
module ovl_retry_fsm #(
   parameter int unsigned ON_TICKS = 100,
   parameter int unsigned CNT_W    = 11
) (
   input  logic                      clk_i,
   input  logic                      rst_i,
   input  logic                      ovl_i,
   input  logic                      tick_i,
   input  logic                      zero_i,
   input  logic [CNT_W-1:0]          off_len_i,
   output ovl_retry_pkg::ovl_state_e state_o,
   output logic                      load_o,
   output logic [CNT_W-1:0]          load_val_o
);
   import ovl_retry_pkg::*;

   localparam logic [CNT_W-1:0] ON_M1 = CNT_W'(ON_TICKS - 1);

   ovl_state_e state_q, state_d;
   logic       win_end;

   assign win_end = tick_i && zero_i;

   always_comb begin
      state_d    = state_q;
      load_o     = 1'b0;
      load_val_o = off_len_i - 1'b1;
      case (state_q)
         ST_IDLE: begin
            if (ovl_i) begin
               state_d = ST_OFF;
               load_o  = 1'b1;
            end
         end
         ST_OFF: begin
            if (win_end) begin
               state_d    = ST_ON;
               load_o     = 1'b1;
               load_val_o = ON_M1;
            end
         end
         ST_ON: begin
            if (win_end) begin
               if (ovl_i) begin
                  state_d = ST_OFF;
                  load_o  = 1'b1;
               end else begin
                  state_d = ST_IDLE;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) state_q <= ST_IDLE;
      else       state_q <= state_d;
   end

   assign state_o = state_q;

   // R2
   idle_entry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_IDLE && ovl_i) |=> (state_q == ST_OFF))
      else $error("overload in idle did not start cool-down");

   // R6
   retry_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_ON && tick_i && zero_i && ovl_i) |=> (state_q == ST_OFF))
      else $error("overload at window end did not retry");

   // R7
   clean_exit_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_ON && tick_i && zero_i && !ovl_i) |=> (state_q == ST_IDLE))
      else $error("clean window end did not exit");

   // R9
   ovl_ignored_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (state_q == ST_OFF && !(tick_i && zero_i)) |=> (state_q == ST_OFF))
      else $error("cool-down left early");

endmodule

// File: rtl/ovl_retry_ctrl.sv
module ovl_retry_ctrl #(
   parameter int unsigned ON_TICKS = 100
) (
   input  logic       clk_i,
   input  logic       rst_i,
   input  logic       ovl_i,
   input  logic       tick_i,
   input  logic [1:0] ratio_sel_i,
   output logic       out_en_o,
   output logic       pulse_act_o
);
   import ovl_retry_pkg::*;

   localparam int unsigned MAX_OFF = ON_TICKS * 14;
   localparam int unsigned CNT_W   = $clog2(MAX_OFF + 1);

   generate
      if (ON_TICKS < 1) begin : g_bad_on
         $error("ON_TICKS must be at least 1");
      end
   endgenerate

   ovl_state_e       state;
   logic             load;
   logic [CNT_W-1:0] load_val;
   logic [CNT_W-1:0] off_len;
   logic [CNT_W-1:0] cnt;
   logic             zero;

   ovl_off_len #(.ON_TICKS(ON_TICKS), .CNT_W(CNT_W)) len_i (
      .ratio_sel_i (ratio_sel_i),
      .off_len_o   (off_len)
   );

   ovl_retry_fsm #(.ON_TICKS(ON_TICKS), .CNT_W(CNT_W)) fsm_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .ovl_i      (ovl_i),
      .tick_i     (tick_i),
      .zero_i     (zero),
      .off_len_i  (off_len),
      .state_o    (state),
      .load_o     (load),
      .load_val_o (load_val)
   );

   ovl_tick_timer #(.CNT_W(CNT_W)) tmr_i (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .load_val_i (load_val),
      .tick_i     (tick_i),
      .cnt_o      (cnt),
      .zero_o     (zero)
   );

   assign out_en_o    = (state != ST_OFF);
   assign pulse_act_o = (state != ST_IDLE);

   // R1
   reset_state_chk: assert property (@(posedge clk_i)
      rst_i |=> (out_en_o && !pulse_act_o))
      else $error("reset state wrong");

   // R4
   on_load_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      ($rose(out_en_o) && pulse_act_o) |-> (cnt == CNT_W'(ON_TICKS - 1)))
      else $error("drive window not loaded with fixed length");

   // R3
   cnt_bound_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt <= CNT_W'(MAX_OFF - 1))
      else $error("timer above longest cool-down");

endmodule

// File: tb/ovl_retry_ctrl_tb_top.sv
module ovl_retry_ctrl_tb_top;

   localparam int ON = 3;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       ovl = 1'b0;
   logic       tick = 1'b1;
   logic [1:0] code = 2'b10;
   logic       out_en, pulse_act;

   int checks = 0;
   int failures = 0;
   int cycles = 0;
   bit done = 1'b0;

   typedef struct {
      logic  en;
      logic  act;
      string tag;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   ovl_retry_ctrl #(.ON_TICKS(ON)) dut_i (
      .clk_i       (clk),
      .rst_i       (rst),
      .ovl_i       (ovl),
      .tick_i      (tick),
      .ratio_sel_i (code),
      .out_en_o    (out_en),
      .pulse_act_o (pulse_act)
   );

   function automatic int ratio(input logic [1:0] c);
      case (c)
         2'b00:   return 4;
         2'b01:   return 8;
         2'b10:   return 10;
         default: return 15;
      endcase
   endfunction

   function automatic int off_len(input logic [1:0] c);
      return ON * (ratio(c) - 1);
   endfunction

   // driver: apply inputs for one edge and queue the outputs expected after it
   task automatic drive(input logic r, input logic o, input logic t,
                        input logic [1:0] c, input logic e, input logic a,
                        input string tag);
      exp_t x;
      @(negedge clk);
      rst  = r;
      ovl  = o;
      tick = t;
      code = c;
      x.en  = e;
      x.act = a;
      x.tag = tag;
      sb_q.push_back(x);
   endtask

   task automatic entry(input logic [1:0] c, input string tag);
      drive(1'b0, 1'b1, 1'b1, c, 1'b0, 1'b1, tag);
   endtask

   // rest of a cool-down window, with overload toggling (ignored, R9)
   task automatic off_rest(input logic [1:0] c, input int n, input string tag);
      for (int i = 0; i < n; i++)
         drive(1'b0, i[0], 1'b1, c, 1'b0, 1'b1, tag);
   endtask

   task automatic on_win(input logic [1:0] c, input string tag);
      for (int i = 0; i < ON; i++)
         drive(1'b0, ~i[0], 1'b1, c, 1'b1, 1'b1, tag);
   endtask

   task automatic exit_step(input logic [1:0] c);
      drive(1'b0, 1'b0, 1'b1, c, 1'b1, 1'b0, "R7");
   endtask

   task automatic retry_step(input logic [1:0] c);
      drive(1'b0, 1'b1, 1'b1, c, 1'b0, 1'b1, "R6");
   endtask

   // monitor: compare each queued expectation after its edge
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (sb_q.size() > 0) begin
            exp_t x;
            x = sb_q.pop_front();
            checks++;
            if (out_en !== x.en || pulse_act !== x.act) begin
               failures++;
               $display("FAIL %s: out_en/pulse_act actual=%b/%b expected=%b/%b",
                        x.tag, out_en, pulse_act, x.en, x.act);
            end
         end
      end
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         failures++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      // R1: reset and idle
      drive(1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, "R1");
      drive(1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, "R1");
      for (int i = 0; i < 3; i++)
         drive(1'b0, 1'b0, i[0], 2'b10, 1'b1, 1'b0, "R1");

      // R3/R4 for every ratio code, with a clean exit (R7)
      for (int c = 0; c < 4; c++) begin
         entry(2'(c), "R2");
         off_rest(2'(c), off_len(2'(c)) - 1, "R3");
         on_win(2'(c), "R4");
         exit_step(2'(c));
      end

      // R6: repeated overload, then exit
      entry(2'b01, "R2");
      off_rest(2'b01, off_len(2'b01) - 1, "R3");
      on_win(2'b01, "R4");
      retry_step(2'b01);
      off_rest(2'b01, off_len(2'b01) - 1, "R6");
      on_win(2'b01, "R6");
      exit_step(2'b01);

      // R5: code change inside both windows
      entry(2'b00, "R2");
      off_rest(2'b11, off_len(2'b00) - 1, "R5");
      on_win(2'b01, "R5");
      retry_step(2'b01);
      off_rest(2'b01, off_len(2'b01) - 1, "R5");
      on_win(2'b11, "R5");
      exit_step(2'b11);

      // R8: edges without tick hold both windows
      entry(2'b00, "R2");
      for (int i = 0; i < 8; i++)
         drive(1'b0, i[0], 1'b0, 2'b00, 1'b0, 1'b1, "R8");
      off_rest(2'b00, off_len(2'b00) - 1, "R8");
      drive(1'b0, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, "R8");
      for (int i = 0; i < 4; i++)
         drive(1'b0, 1'b0, 1'b0, 2'b00, 1'b1, 1'b1, "R8");
      drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, "R8");
      drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, "R8");
      drive(1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, "R8");
      exit_step(2'b00);

      // R9: overload held high inside cool-down does not restart it
      entry(2'b00, "R2");
      for (int i = 0; i < off_len(2'b00) - 1; i++)
         drive(1'b0, 1'b1, 1'b1, 2'b00, 1'b0, 1'b1, "R9");
      on_win(2'b00, "R9");
      exit_step(2'b00);

      // R1: reset in the middle of a cool-down
      entry(2'b10, "R2");
      off_rest(2'b10, 4, "R3");
      drive(1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b0, "R1");
      drive(1'b0, 1'b0, 1'b1, 2'b10, 1'b1, 1'b0, "R1");

      wait (sb_q.size() == 0);
      @(posedge clk);
      #8;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule